// File: doc/BRIEF.md
# Subtract-and-Branch Processor Core

This block is a multi-cycle processor whose only operation is "subtract, store, and jump if the result is not positive". Code and data live in one word-addressed memory outside the block. The memory has a single port and a synchronous read. The core walks the instruction words, fetches both operands, writes the difference back to memory, and then takes the branch target or moves on to the next instruction.

Two instruction forms exist, and a mode input picks one of them for a whole run. The three-word form subtracts one memory cell from another. The two-word form subtracts an internal accumulator from a memory cell and then keeps the result in the accumulator. A branch to the all-ones address stops the machine. A start pulse launches a program from a fixed address, and a debug output shows the program counter.

Top module: `sbz_core`

## Requirements
- R1: After reset the core is idle: `busy`=0, `halted`=0, `mem_we`=0 and `pc_dbg` equals START_ADDR (0 by default).
- R2: A `start` pulse while the core is idle or halted latches `mode_acc`, clears the accumulator, loads START_ADDR into the program counter and begins execution. While `busy`=1, both `start` and `mode_acc` have no effect.
- R3: With `mode_acc`=0, the words at pc, pc+1 and pc+2 are the addresses A, B and T, taken from their low ADDR_W bits. The core writes Mem[B] - Mem[A], modulo 2^DATA_W, into Mem[B].
- R4: The branch is taken when the written result, read as two's complement, is zero or negative; pc then becomes T. Otherwise pc advances by 3 in the three-word form and by 2 in the two-word form, wrapping modulo 2^ADDR_W.
- R5: With `mode_acc`=1, the words at pc and pc+1 are the addresses A and T. The core writes Mem[A] - acc into Mem[A] and also loads that result into the accumulator.
- R6: A taken branch whose target is the all-ones address (255 by default) halts the core. `halted` goes to 1, `pc_dbg` keeps the address of the halting instruction, and no memory write happens until the next `start`.
- R7: A three-word instruction keeps `busy` high for exactly 6 cycles and a two-word instruction for exactly 4. Each instruction performs exactly one memory write, in its last cycle.
- R8: The read data for an address on `mem_addr` is expected on `mem_rdata` in the following cycle. A write is requested by `mem_we`=1 together with `mem_addr` and `mem_wdata`.
- R9: In the three-word form, the sequence (B,B), (A,Z), (Z,B), (Z,Z), with Z a cell holding zero, copies Mem[A] into Mem[B] and leaves Z at zero, for every value of Mem[A].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a program when the core is idle or halted |
| mode_acc | input | 1 | 0: three-word form, 1: two-word accumulator form |
| mem_addr | output | ADDR_W | Memory word address |
| mem_we | output | 1 | Memory write request |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the address |
| busy | output | 1 | Core is executing |
| halted | output | 1 | Core has stopped on the halt target |
| pc_dbg | output | ADDR_W | Current program counter |

## Verification
The bench sweeps operand values that include zero, plus and minus one, and the two extreme integers. This catches a branch test that looks only at the sign bit, so that zero falls through, or only at zero, so that negatives fall through; either fault leaves the halt address on the wrong stub. Wrap-around in subtraction is covered by the copy of the most negative value, where an error corrupts the copied word. It is also covered by the accumulator runs, where a stale or uncleared accumulator from the previous run shifts every result. Countdown loops take branches backwards, and spurious `start` and mode toggles are applied mid-run. Together these expose a core that restarts, loses its latched mode or takes the wrong number of cycles, because the busy-cycle count and the memory image would then no longer match the arithmetic model.

// File: rtl/sbz_pkg.sv
package sbz_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_W0,
      ST_W1,
      ST_W2,
      ST_W3,
      ST_OPA,
      ST_OPB,
      ST_HALT
   } sbz_state_e;

endpackage

// File: rtl/sbz_alu.sv
module sbz_alu #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] minuend,
   input  logic [DATA_W-1:0] subtrahend,
   output logic [DATA_W-1:0] diff,
   output logic              le_zero
);

   always_comb begin
      diff    = minuend - subtrahend;
      le_zero = diff[DATA_W-1] | (diff == '0);
   end

endmodule

// File: rtl/sbz_accum.sv
module sbz_accum #(
   parameter int DATA_W = 16,
   parameter bit ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);

   generate
      if (ENABLE) begin : g_acc
         logic [DATA_W-1:0] acc_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    acc_r <= '0;
            else if (clr)  acc_r <= '0;
            else if (load) acc_r <= d;
         end

         assign q = acc_r;

         // R5: the accumulator moves only on a clear or a write-back load
         assert_acc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && !load) |=> $stable(q));
      end else begin : g_no_acc
         logic unused_acc_inputs;
         assign unused_acc_inputs = ^{clk, rst_n, clr, load, d};
         assign q = '0;
      end
   endgenerate

endmodule

// File: rtl/sbz_ctrl.sv
module sbz_ctrl
   import sbz_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 8,
   parameter int START_ADDR = 0,
   parameter bit HAS_ACC    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mode,
   input  logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-1:0] acc_q,
   input  logic [DATA_W-1:0] diff,
   input  logic              le,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] sub_operand,
   output logic              acc_clr,
   output logic              acc_load,
   output logic              busy,
   output logic              halted,
   output logic [ADDR_W-1:0] pc_q
);

   localparam logic [ADDR_W-1:0] HALT_ADDR = '1;
   localparam logic [ADDR_W-1:0] START_PC  = ADDR_W'(START_ADDR);

   sbz_state_e        state;
   logic [ADDR_W-1:0] wa, wb, tgt;
   logic [DATA_W-1:0] opa;
   logic              mode_q;
   logic [ADDR_W-1:0] rd_addr;
   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] dst;
   logic              launch;

   assign rd_addr     = rd_data[ADDR_W-1:0];
   assign step        = mode_q ? ADDR_W'(2) : ADDR_W'(3);
   assign dst         = mode_q ? wa : wb;
   assign busy        = (state != ST_IDLE) && (state != ST_HALT);
   assign halted      = (state == ST_HALT);
   assign launch      = start && !busy;
   assign acc_clr     = launch;
   assign acc_load    = (state == ST_OPB) && mode_q;
   assign sub_operand = mode_q ? acc_q : opa;
   assign mem_wdata   = diff;

   always_comb begin
      mem_addr = pc_q;
      mem_we   = 1'b0;
      case (state)
         ST_W1:   mem_addr = pc_q + ADDR_W'(1);
         ST_W2:   mem_addr = mode_q ? wa : pc_q + ADDR_W'(2);
         ST_W3:   mem_addr = wa;
         ST_OPA:  mem_addr = wb;
         ST_OPB: begin
            mem_addr = dst;
            mem_we   = 1'b1;
         end
         default: mem_addr = pc_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         pc_q   <= START_PC;
         wa     <= '0;
         wb     <= '0;
         tgt    <= '0;
         opa    <= '0;
         mode_q <= 1'b0;
      end else begin
         case (state)
            ST_IDLE, ST_HALT: begin
               if (start) begin
                  state  <= ST_W0;
                  pc_q   <= START_PC;
                  mode_q <= mode & HAS_ACC;
               end
            end
            ST_W0: state <= ST_W1;
            ST_W1: begin
               wa    <= rd_addr;
               state <= ST_W2;
            end
            ST_W2: begin
               if (mode_q) begin
                  tgt   <= rd_addr;
                  state <= ST_OPB;
               end else begin
                  wb    <= rd_addr;
                  state <= ST_W3;
               end
            end
            ST_W3: begin
               tgt   <= rd_addr;
               state <= ST_OPA;
            end
            ST_OPA: begin
               opa   <= rd_data;
               state <= ST_OPB;
            end
            ST_OPB: begin
               if (le && (tgt == HALT_ADDR)) begin
                  state <= ST_HALT;
               end else begin
                  pc_q  <= le ? tgt : pc_q + step;
                  state <= ST_W0;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R6: a halted core stays halted with a frozen pc until restarted
   assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !start) |=> (halted && $stable(pc_q)));

   // R6: no memory write outside execution
   assert_no_idle_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_we);

   // R4: taken branch to a normal target loads pc with the target
   assert_taken_branch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && le && (tgt != HALT_ADDR)) |=> (pc_q == $past(tgt)));

   // R4: untaken branch advances by the instruction length
   assert_fall_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !le) |=> (pc_q == ADDR_W'($past(pc_q) + $past(step))));

   // R7: one write per instruction, never back to back
   assert_single_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

endmodule

// File: rtl/sbz_core.sv
module sbz_core #(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 8,
   parameter int START_ADDR = 0,
   parameter bit HAS_ACC    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mode_acc,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              halted,
   output logic [ADDR_W-1:0] pc_dbg
);

   generate
      if (ADDR_W < 2 || ADDR_W > DATA_W) begin : g_bad_addr_w
         $error("sbz_core: ADDR_W must lie between 2 and DATA_W");
      end
      if (START_ADDR < 0 || START_ADDR >= (1 << ADDR_W) - 1) begin : g_bad_start
         $error("sbz_core: START_ADDR must be below the halt address");
      end
   endgenerate

   logic [DATA_W-1:0] diff;
   logic              le;
   logic [DATA_W-1:0] sub_operand;
   logic [DATA_W-1:0] acc_q;
   logic              acc_clr;
   logic              acc_load;

   sbz_alu #(.DATA_W(DATA_W)) u_alu (
      .minuend    (mem_rdata),
      .subtrahend (sub_operand),
      .diff       (diff),
      .le_zero    (le)
   );

   sbz_accum #(.DATA_W(DATA_W), .ENABLE(HAS_ACC)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (acc_clr),
      .load  (acc_load),
      .d     (diff),
      .q     (acc_q)
   );

   sbz_ctrl #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .START_ADDR (START_ADDR),
      .HAS_ACC    (HAS_ACC)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .mode        (mode_acc),
      .rd_data     (mem_rdata),
      .acc_q       (acc_q),
      .diff        (diff),
      .le          (le),
      .mem_addr    (mem_addr),
      .mem_we      (mem_we),
      .mem_wdata   (mem_wdata),
      .sub_operand (sub_operand),
      .acc_clr     (acc_clr),
      .acc_load    (acc_load),
      .busy        (busy),
      .halted      (halted),
      .pc_q        (pc_dbg)
   );

endmodule

// File: tb/sbz_core_bench.sv
`timescale 1ns/1ps
module sbz_core_bench;

   localparam int DW = 16;
   localparam int AW = 8;
   localparam int MW = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          mode_acc = 1'b0;
   logic [AW-1:0] mem_addr;
   logic          mem_we;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata;
   logic          busy, halted;
   logic [AW-1:0] pc_dbg;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   logic [DW-1:0] mem   [MW];
   logic [DW-1:0] ref_m [MW];

   always #5 clk = ~clk;

   sbz_core u_sbz_core (
      .clk (clk), .rst_n (rst_n), .start (start), .mode_acc (mode_acc),
      .mem_addr (mem_addr), .mem_we (mem_we), .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata), .busy (busy), .halted (halted), .pc_dbg (pc_dbg)
   );

   // R8: synchronous single-port memory, read data one cycle later
   always_ff @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < MW; i++) mem[i] = 16'h0000;
   endtask

   task automatic put3(input int at, input int a, input int b, input int t);
      mem[at] = DW'(a); mem[at+1] = DW'(b); mem[at+2] = DW'(t);
   endtask

   task automatic put2(input int at, input int a, input int t);
      mem[at] = DW'(a); mem[at+1] = DW'(t);
   endtask

   // Arithmetic model of the instruction set on ref_m
   task automatic ref_run(input bit md, output int hpc, output int ninstr);
      logic [AW-1:0] p = '0;
      logic [DW-1:0] acc = '0;
      logic [DW-1:0] r;
      logic [AW-1:0] a, b, t;
      hpc = -1;
      ninstr = 0;
      for (int k = 0; k < 2000; k++) begin
         a = ref_m[p][AW-1:0];
         if (md) begin
            t = ref_m[AW'(p + 1)][AW-1:0];
            r = ref_m[a] - acc;
            ref_m[a] = r;
            acc = r;
         end else begin
            b = ref_m[AW'(p + 1)][AW-1:0];
            t = ref_m[AW'(p + 2)][AW-1:0];
            r = ref_m[b] - ref_m[a];
            ref_m[b] = r;
         end
         ninstr++;
         if ($signed(r) <= 0) begin
            if (t == '1) begin
               hpc = int'(p);
               break;
            end
            p = t;
         end else begin
            p = p + (md ? AW'(2) : AW'(3));
         end
      end
   endtask

   // Runs the program in mem, optionally disturbing start/mode mid-run
   task automatic run_and_compare(input bit md, input bit disturb, input string req);
      int hpc, ninstr, cyc, bad, first;
      for (int i = 0; i < MW; i++) ref_m[i] = mem[i];
      ref_run(md, hpc, ninstr);
      @(negedge clk);
      mode_acc = md;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      for (int w = 0; w < 20000; w++) begin
         if (halted) break;
         if (busy) cyc++;
         if (disturb && cyc == 3) begin
            start = 1'b1;
            mode_acc = ~md;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      check(halted == 1'b1, "R6", "halted after run", int'(halted), 1);
      check(int'(pc_dbg) == hpc, "R6", "halt pc", int'(pc_dbg), hpc);
      check(cyc == ninstr * (md ? 4 : 6), "R7", "busy cycles", cyc, ninstr * (md ? 4 : 6));
      bad = 0;
      first = -1;
      for (int i = 0; i < MW; i++) begin
         if (mem[i] !== ref_m[i]) begin
            bad++;
            if (first < 0) first = i;
         end
      end
      if (first < 0) first = 0;
      check(bad == 0, req, $sformatf("memory word %0d", first),
            int'($signed(mem[first])), int'($signed(ref_m[first])));
      // R2: a spurious start or mode flip mid-run is ignored
      if (disturb)
         check(bad == 0 && cyc == ninstr * (md ? 4 : 6), "R2", "disturbed run intact",
               bad, 0);
   endtask

   function automatic logic [DW-1:0] pick(input int i);
      case (i)
         0: return 16'h0000;
         1: return 16'h0001;
         2: return 16'hFFFF;
         3: return 16'h7FFF;
         4: return 16'h8000;
         5: return 16'h0064;
         6: return 16'hFF9C;
         default: return 16'h0002;
      endcase
   endfunction

   initial begin
      #(10ns * 190000);
      if (!finished) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual hung expected halt");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      clear_mem();
      repeat (3) @(negedge clk);
      // R1: reset state
      check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
      check(halted == 1'b0, "R1", "halted in reset", int'(halted), 0);
      check(mem_we == 1'b0, "R1", "mem_we in reset", int'(mem_we), 0);
      check(pc_dbg == '0, "R1", "pc in reset", int'(pc_dbg), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(busy == 1'b0 && halted == 1'b0, "R1", "idle after reset", int'(busy), 0);

      // R9: copy sequence over a spread of values
      for (int i = 0; i < 48; i++) begin
         logic [DW-1:0] v;
         v = (i < 8) ? pick(i) : DW'(i * 1399 + 17);
         clear_mem();
         put3(0, 201, 201, 3);
         put3(3, 200, 202, 6);
         put3(6, 202, 201, 9);
         put3(9, 202, 202, 12);
         put3(12, 203, 203, 255);
         mem[200] = v;
         mem[201] = DW'(16'h5A5A ^ i);
         run_and_compare(1'b0, i[0], "R3");
         check(mem[201] == v, "R9", "copied value", int'($signed(mem[201])), int'($signed(v)));
         check(mem[202] == 16'h0000, "R9", "scratch zero", int'(mem[202]), 0);
         check(mem[200] == v, "R9", "source intact", int'($signed(mem[200])), int'($signed(v)));
      end

      // R3 R4: single three-word instruction, both branch outcomes
      for (int x = 0; x < 8; x++) begin
         for (int y = 0; y < 8; y++) begin
            logic [DW-1:0] d;
            clear_mem();
            put3(0, 210, 211, 9);
            put3(3, 212, 212, 255);
            put3(9, 212, 212, 255);
            mem[210] = pick(x);
            mem[211] = pick(y);
            d = pick(y) - pick(x);
            run_and_compare(1'b0, 1'b0, "R3");
            check(mem[211] == d, "R3", "difference", int'($signed(mem[211])), int'($signed(d)));
            check(int'(pc_dbg) == (($signed(d) <= 0) ? 9 : 3), "R4", "branch outcome",
                  int'(pc_dbg), ($signed(d) <= 0) ? 9 : 3);
         end
      end

      // R5 R4 R2: two-word accumulator form, accumulator cleared per run
      for (int x = 0; x < 8; x++) begin
         for (int y = 0; y < 8; y++) begin
            clear_mem();
            put2(0, 220, 100);
            put2(2, 221, 100);
            put2(4, 222, 255);
            put2(6, 222, 255);
            put2(100, 222, 255);
            put2(102, 222, 255);
            mem[220] = pick(x);
            mem[221] = pick(y);
            run_and_compare(1'b1, (x == y), "R5");
         end
      end

      // R4 R7: backward-branch countdown loops
      for (int n = 1; n <= 10; n++) begin
         clear_mem();
         put3(0, 230, 231, 6);
         put3(3, 232, 232, 0);
         put3(6, 232, 232, 255);
         mem[230] = 16'h0001;
         mem[231] = DW'(n);
         run_and_compare(1'b0, 1'b0, "R4");
         check(int'(mem[231]) == 0, "R4", "countdown result", int'(mem[231]), 0);
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule